// File: doc/BRIEF.md
# Debug Session Handshake Tracker

This block sits on the scan-clock side of a processor debug unit and follows the life of a debug session. The core raises a debug-entry level in its own clock domain. The block brings that level across into the scan-clock domain and looks for its rising edge. On that edge it answers with a fixed-length acknowledge pulse. The pulse is active high, so it can drive the enable of an open-drain pulldown on a shared active-low debug-event line. It can also act as a plain handshake back to the requester when no such line exists.

The same edge sets an active-low session flag. Peripherals watch this flag to change how they behave while the processor is under debug control. The flag stays set while the core steps in and out of the debug state one instruction at a time.

The flag is cleared only by one kind of update to the debug command register: a resume-and-execute command that selects either "no register" or the CPU scan-chain register. The block decodes every command update for this release condition.

Top module: `dbg_session_tracker`

## Requirements
- R1: A rising edge on `dbg_entry_i` makes `ack_o` high for exactly `ACK_CYCLES` (default 3) scan-clock cycles. `ack_o` first reads high after the (`SYNC_STAGES`+1)-th rising clock edge at which the input is sampled high: two synchronizer stages plus one edge-detect register.
- R2: Only a low-to-high change of `dbg_entry_i` produces a pulse. Holding the input high gives a single pulse, a falling edge gives none, and `ack_o` stays low when no entry occurs.
- R3: A detected entry drives `session_no` low. This happens at the same clock edge at which `ack_o` rises.
- R4: A command update (`cmd_upd_i`=1) releases the session and drives `session_no` high at the next clock edge when three conditions hold: `cmd_i[8]` (GO) is 1, `cmd_i[7]` (EX) is 1, and `cmd_i[6:0]` is 7'h7F (no register) or 7'h10 (CPU scan-chain register). `cmd_i[9]` (read/write) does not matter.
- R5: `session_no` stays low while `dbg_entry_i` toggles repeatedly for single-stepped instructions.
- R6: The session flag does not change for any of these: a command update with GO set and EX clear, one with EX set and GO clear, one with any other register select, or a valid release code presented while `cmd_upd_i` is 0.
- R7: An entry edge that is detected while a pulse is running neither restarts nor lengthens that pulse.
- R8: Asserting `rst_ni` low clears `ack_o` and sets `session_no` high at once, without a clock edge. Release of the reset takes effect on the clock.
- R9: When an entry edge and a release command fall on the same clock edge, the entry wins and `session_no` ends up low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Scan clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dbg_entry_i | input | 1 | Debug-entry level from the CPU clock domain |
| cmd_upd_i | input | 1 | Command register update strobe |
| cmd_i | input | 10 | Command value: [9] R/W, [8] GO, [7] EX, [6:0] register select |
| ack_o | output | 1 | Acknowledge pulse, active high (pulldown enable) |
| session_no | output | 1 | Debug session active, active low |

## Verification
Single entry edges measure the pulse latency and its length. An entry held high for many cycles, and a falling edge, tell edge detection apart from level detection. A second edge timed to land inside a running pulse shows whether the pulse counter is retriggerable. Command patterns that differ by one field from a release (GO only, EX only, a foreign select, no strobe) are set against the two real release codes with both read/write values. Together with a release and an entry landing on the same edge, these patterns show both how exact the decode is and which of set and clear takes priority.

// File: rtl/dbg_trk_pkg.sv
package dbg_trk_pkg;

  localparam int CMD_W = 10;
  localparam int SEL_W = 7;

  typedef struct packed {
    logic             rw;
    logic             go;
    logic             ex;
    logic [SEL_W-1:0] sel;
  } dbg_cmd_t;

  localparam logic [SEL_W-1:0] SEL_NONE   = 7'h7F;
  localparam logic [SEL_W-1:0] SEL_CPUSCR = 7'h10;

endpackage

// File: rtl/dbg_sync_chain.sv
module dbg_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d[0] = d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_shift
    always_comb begin
      stage_d[g] = stage_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/dbg_ack_timer.sv
module dbg_ack_timer #(
  parameter int ACK_CYCLES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic rise_o,
  output logic ack_o
);

  localparam int CNT_W = $clog2(ACK_CYCLES + 1);

  logic             prev_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             busy;
  logic             load;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= level_i;
    end
  end

  assign rise_o = level_i & ~prev_q;
  assign busy   = (cnt_q != '0);
  assign load   = rise_o & ~busy;

  always_comb begin
    cnt_en = load | busy;
    if (load) begin
      cnt_d = CNT_W'(ACK_CYCLES);
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign ack_o = busy;

endmodule

// File: rtl/dbg_release_decode.sv
module dbg_release_decode
  import dbg_trk_pkg::*;
(
  input  logic             upd_i,
  input  logic [CMD_W-1:0] cmd_i,
  output logic             release_o
);

  dbg_cmd_t cmd;
  logic     sel_ok;
  logic     unused_rw;

  assign cmd       = dbg_cmd_t'(cmd_i);
  assign unused_rw = cmd.rw;

  always_comb begin
    sel_ok    = (cmd.sel == SEL_NONE) | (cmd.sel == SEL_CPUSCR);
    release_o = upd_i & cmd.go & cmd.ex & sel_ok;
  end

endmodule

// File: rtl/dbg_session_tracker.sv
module dbg_session_tracker
  import dbg_trk_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ACK_CYCLES  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dbg_entry_i,
  input  logic             cmd_upd_i,
  input  logic [CMD_W-1:0] cmd_i,
  output logic             ack_o,
  output logic             session_no
);

  logic rst_sync_n;
  logic entry_sync;
  logic entry_rise;
  logic release_cmd;
  logic sess_q;
  logic sess_d;
  logic sess_en;

  // reset: asserted asynchronously, deasserted on the clock
  dbg_sync_chain #(
    .STAGES(2)
  ) u_rst_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (1'b1),
    .q_o   (rst_sync_n)
  );

  dbg_sync_chain #(
    .STAGES(SYNC_STAGES)
  ) u_entry_sync (
    .clk_i (clk_i),
    .rst_ni(rst_sync_n),
    .d_i   (dbg_entry_i),
    .q_o   (entry_sync)
  );

  dbg_ack_timer #(
    .ACK_CYCLES(ACK_CYCLES)
  ) u_ack (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .level_i(entry_sync),
    .rise_o (entry_rise),
    .ack_o  (ack_o)
  );

  dbg_release_decode u_dec (
    .upd_i    (cmd_upd_i),
    .cmd_i    (cmd_i),
    .release_o(release_cmd)
  );

  // entry takes priority over release
  always_comb begin
    sess_en = entry_rise | release_cmd;
    sess_d  = entry_rise;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sess_q <= 1'b0;
    end else if (sess_en) begin
      sess_q <= sess_d;
    end
  end

  assign session_no = ~sess_q;

endmodule

// File: rtl/dbg_session_tracker_chk.sv
module dbg_session_tracker_chk
  import dbg_trk_pkg::*;
#(
  parameter int ACK_CYCLES = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_upd_i,
  input logic [CMD_W-1:0] cmd_i,
  input logic             ack_o,
  input logic             session_no
);

  localparam int RUN_W = $clog2(ACK_CYCLES + 1) + 1;

  logic [RUN_W-1:0] run_q;
  logic             rst_q;
  logic             rel_cmd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
    end else if (ack_o) begin
      run_q <= run_q + 1'b1;
    end else begin
      run_q <= '0;
    end
  end

  always_ff @(posedge clk_i) begin
    rst_q <= rst_ni;
  end

  assign rel_cmd = cmd_upd_i && cmd_i[8] && cmd_i[7] &&
                   ((cmd_i[6:0] == SEL_NONE) || (cmd_i[6:0] == SEL_CPUSCR));

  AST_ACK_NOT_LONG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (run_q < RUN_W'(ACK_CYCLES))); // R7

  AST_ACK_FULL_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_o) |-> (run_q == RUN_W'(ACK_CYCLES))); // R1

  AST_SESSION_ON_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> !session_no); // R3

  AST_CLEAR_ONLY_ON_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(session_no) |-> $past(rel_cmd)); // R4

  always_ff @(posedge clk_i) begin
    if (!rst_q && !rst_ni) begin
      AST_RESET_STATE: assert (!ack_o && session_no); // R8
    end
  end

endmodule

bind dbg_session_tracker dbg_session_tracker_chk #(
  .ACK_CYCLES(ACK_CYCLES)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cmd_upd_i (cmd_upd_i),
  .cmd_i     (cmd_i),
  .ack_o     (ack_o),
  .session_no(session_no)
);

// File: tb/tb_dbg_session_tracker.sv
`timescale 1ns/1ps
module tb_dbg_session_tracker;

  localparam int SYNC = 2;
  localparam int ACKN = 3;

  logic       clk_i;
  logic       rst_ni;
  logic       dbg_entry_i;
  logic       cmd_upd_i;
  logic [9:0] cmd_i;
  logic       ack_o;
  logic       session_no;

  int vectors;
  int errors;
  bit done;

  dbg_session_tracker #(.SYNC_STAGES(SYNC), .ACK_CYCLES(ACKN)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .dbg_entry_i(dbg_entry_i),
    .cmd_upd_i(cmd_upd_i), .cmd_i(cmd_i), .ack_o(ack_o), .session_no(session_no)
  );

  initial clk_i = 1'b0;
  always #2 clk_i = ~clk_i;

  task automatic chk(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    dbg_entry_i = 1'b0;
    repeat (n) @(negedge clk_i);
  endtask

  // raise entry at a negedge and check the pulse window
  task automatic entry_pulse(input string req, input logic sess_before);
    dbg_entry_i = 1'b1;
    for (int i = 0; i < SYNC; i++) begin
      @(negedge clk_i);
      chk(req, ack_o, 1'b0);
      chk(req, session_no, sess_before);
    end
    for (int i = 0; i < ACKN; i++) begin
      @(negedge clk_i);
      chk(req, ack_o, 1'b1);
      chk("R3", session_no, 1'b0);
    end
    @(negedge clk_i);
    chk(req, ack_o, 1'b0);
  endtask

  task automatic send_cmd(input logic upd, input logic [9:0] c);
    cmd_upd_i = upd;
    cmd_i     = c;
    @(negedge clk_i);
    cmd_upd_i = 1'b0;
    cmd_i     = '0;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; dbg_entry_i = 1'b0; cmd_upd_i = 1'b0; cmd_i = '0;
    repeat (3) @(negedge clk_i);
    chk("R8", ack_o, 1'b0);
    chk("R8", session_no, 1'b1);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk("R2", ack_o, 1'b0);
    chk("R8", session_no, 1'b1);
  endtask

  task automatic t_basic_entry();
    entry_pulse("R1", 1'b1);
    idle(6);
  endtask

  task automatic t_held_level();
    entry_pulse("R1", session_no);
    repeat (20) begin
      @(negedge clk_i);
      chk("R2", ack_o, 1'b0);
    end
    dbg_entry_i = 1'b0;
    repeat (8) begin
      @(negedge clk_i);
      chk("R2", ack_o, 1'b0);
    end
  endtask

  task automatic t_retrigger();
    idle(6);
    dbg_entry_i = 1'b1;
    @(negedge clk_i);
    dbg_entry_i = 1'b0;
    @(negedge clk_i);
    dbg_entry_i = 1'b1;
    for (int i = 0; i < ACKN; i++) begin
      @(negedge clk_i);
      chk("R7", ack_o, 1'b1);
    end
    repeat (4) begin
      @(negedge clk_i);
      chk("R7", ack_o, 1'b0);
    end
    idle(6);
  endtask

  task automatic t_single_step();
    for (int k = 0; k < 3; k++) begin
      dbg_entry_i = 1'b0;
      repeat (4) @(negedge clk_i);
      chk("R5", session_no, 1'b0);
      dbg_entry_i = 1'b1;
      repeat (6) @(negedge clk_i);
      chk("R5", session_no, 1'b0);
    end
    send_cmd(1'b1, {1'b0, 1'b1, 1'b0, 7'h7F});
    chk("R6", session_no, 1'b0);
    send_cmd(1'b1, {1'b0, 1'b0, 1'b1, 7'h10});
    chk("R6", session_no, 1'b0);
    send_cmd(1'b1, {1'b0, 1'b1, 1'b1, 7'h05});
    chk("R6", session_no, 1'b0);
    send_cmd(1'b0, {1'b0, 1'b1, 1'b1, 7'h7F});
    chk("R6", session_no, 1'b0);
    idle(6);
  endtask

  task automatic t_release();
    send_cmd(1'b1, {1'b0, 1'b1, 1'b1, 7'h7F});
    chk("R4", session_no, 1'b1);
    entry_pulse("R1", 1'b1);
    idle(6);
    send_cmd(1'b1, {1'b1, 1'b1, 1'b1, 7'h10});
    chk("R4", session_no, 1'b1);
    repeat (3) @(negedge clk_i);
    chk("R4", session_no, 1'b1);
  endtask

  task automatic t_collision();
    idle(6);
    dbg_entry_i = 1'b1;
    repeat (SYNC) @(negedge clk_i);
    cmd_upd_i = 1'b1;
    cmd_i     = {1'b0, 1'b1, 1'b1, 7'h7F};
    @(negedge clk_i);
    cmd_upd_i = 1'b0;
    cmd_i     = '0;
    chk("R9", session_no, 1'b0);
    chk("R9", ack_o, 1'b1);
    idle(6);
  endtask

  task automatic t_async_reset();
    entry_pulse("R1", session_no);
    idle(6);
    send_cmd(1'b1, {1'b0, 1'b1, 1'b1, 7'h10});
    dbg_entry_i = 1'b1;
    repeat (SYNC + 1) @(negedge clk_i);
    chk("R8", ack_o, 1'b1);
    #1;
    rst_ni = 1'b0;
    #0.5;
    chk("R8", ack_o, 1'b0);
    chk("R8", session_no, 1'b1);
    dbg_entry_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (6) @(negedge clk_i);
    chk("R8", ack_o, 1'b0);
    chk("R8", session_no, 1'b1);
  endtask

  initial begin
    vectors = 0;
    errors  = 0;
    done    = 1'b0;
    t_reset();
    t_basic_entry();
    t_held_level();
    t_retrigger();
    t_single_step();
    t_release();
    t_collision();
    t_async_reset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule